// File: doc/BRIEF.md
# Reloading Down-Counter Timer

A small bus-attached timer with a 32-bit word register port. Software loads a 16-bit period value and then sets the enable bit in the control word. From then on, every pulse on `tick_en` lowers the count by one. When the count has reached zero, the next pulse refills it from the stored period value. The timer therefore repeats forever with a period of `reload + 1` ticks. `tick_en` is a one-cycle strobe that the surrounding system derives from its clock, once per microsecond.

Writing the control word with its top bit set clears the timer completely and discards the word. Clearing the enable bit with an ordinary control write freezes the count. The count register is read-only, and offsets in the 256-byte window that map to no register read as zero. Reads return their data one cycle after the read strobe.

Top module: `ucount_timer`

## Requirements
- R1: After `rst_n` is deasserted, reads of the control (0x00), period (0x04) and count (0x08) registers all return 0.
- R2: A write to 0x00 with bit 31 clear stores the full 32-bit word, and a later read of 0x00 returns it unchanged.
- R3: A write to 0x04 keeps only bits 15:0 as the period, so a read of 0x04 returns the word with bits 31:16 cleared. The same write also loads the count with that 16-bit value.
- R4: While control bit 0 is 1, each cycle with `tick_en` high and a nonzero count lowers the count by exactly 1. A read of 0x08 returns the count in bits 15:0 with zeros above.
- R5: While control bit 0 is 1, a `tick_en` pulse that finds the count at 0 loads the count with the period value. The count sequence therefore repeats every period+1 ticks.
- R6: While control bit 0 is 0, `tick_en` pulses leave the count unchanged.
- R7: A write to 0x00 with bit 31 set clears the control, period and count to 0, and none of the written word is stored.
- R8: Writes to 0x08 change neither the count nor any other register.
- R9: A read of any byte offset other than 0x00, 0x04 or 0x08 returns 0, including offsets that are not word aligned. A write to such an offset changes no register.
- R10: `rdata` takes the addressed value on the clock edge where `rd_en` is sampled high and holds it until the next read.
- R11: When a write to 0x04 and a `tick_en` pulse fall in the same cycle, the write wins: the count takes the written value and is not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle count strobe (1 MHz rate) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte offset into the register window |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |

## Verification
The bench uses the default parameters: an 8-bit offset, a 32-bit word and a 16-bit count. With an 8-bit offset, the whole 256-byte window can be swept one byte at a time. Every unmapped offset is written with an all-ones word and then read back, and the mapped registers are checked for disturbance after each write. Small period values from 0 to 5 make it cheap to run each period through more than two full wraps and to compare every count against arithmetic in the bench. A single write of 0xABCD1234 to the period register covers the truncation of the upper 16 bits.

// File: rtl/ucount_timer.sv
module ucount_timer #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int EN_BIT  = 0,
  parameter int CLR_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_PER  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(8'h08);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  period_q, count_q;

  wire sel_ctrl = addr == OFF_CTRL;
  wire sel_per  = addr == OFF_PER;
  wire sel_cnt  = addr == OFF_CNT;
  wire clr_wr   = wr_en && sel_ctrl && wdata[CLR_BIT];
  wire ctl_wr   = wr_en && sel_ctrl && !wdata[CLR_BIT];
  wire per_wr   = wr_en && sel_per;
  wire running  = ctrl_q[EN_BIT];
  wire step     = running && tick_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
      count_q  <= '0;
    end else if (clr_wr) begin
      ctrl_q   <= '0;
      period_q <= '0;
      count_q  <= '0;
    end else begin
      if (ctl_wr) ctrl_q <= wdata;
      if (per_wr) begin
        period_q <= wdata[CNT_W-1:0];
        count_q  <= wdata[CNT_W-1:0];
      end else if (step) begin
        count_q <= (count_q == '0) ? period_q : count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= sel_ctrl ? ctrl_q :
               sel_per  ? {{PAD_W{1'b0}}, period_q} :
               sel_cnt  ? {{PAD_W{1'b0}}, count_q} : '0;
  end

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (ctrl_q == '0 && period_q == '0 && count_q == '0)); // R7
  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctrl_q == $past(wdata)); // R2
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en) |=> $stable(count_q)); // R6
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_en && !wr_en && count_q != '0) |=> count_q == $past(count_q) - 1'b1); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_en && !wr_en && count_q == '0) |=> count_q == $past(period_q)); // R5
  AST_CNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_cnt && !tick_en) |=> ($stable(count_q) && $stable(ctrl_q) && $stable(period_q))); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_ctrl && !sel_per && !sel_cnt) |=> rdata == '0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R10
endmodule

// File: tb/tb_ucount_timer.sv
module tb_ucount_timer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick_en = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  int checks = 0, fails = 0;
  bit  done = 0;

  ucount_timer dut (.clk, .rst_n, .tick_en, .wr_en, .rd_en, .addr, .wdata, .rdata);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    logic [15:0] exp_cnt;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h04, v); chk("R1 period", v, 0);
    rd(8'h08, v); chk("R1 count", v, 0);

    wr(8'h00, 32'h1234_5670); rd(8'h00, v); chk("R2 ctrl store", v, 32'h1234_5670);
    wr(8'h00, 32'h7FFF_FFFE); rd(8'h00, v); chk("R2 ctrl store", v, 32'h7FFF_FFFE);

    wr(8'h04, 32'hABCD_1234); rd(8'h04, v); chk("R3 period trunc", v, 32'h0000_1234);
    rd(8'h08, v); chk("R3 count load", v, 32'h0000_1234);

    // R9 sweep: ctrl holds 0x7FFFFFFE (stopped), period 0x1234
    for (int a = 0; a < 256; a++) begin
      if (a == 0 || a == 4 || a == 8) continue;
      wr(8'(a), 32'hFFFF_FFFF);
      rd(8'(a), v); chk("R9 unmapped read", v, 0);
      rd(8'h00, v); chk("R9 ctrl intact", v, 32'h7FFF_FFFE);
      rd(8'h04, v); chk("R9 period intact", v, 32'h1234);
      rd(8'h08, v); chk("R9 count intact", v, 32'h1234);
    end

    // R6 stopped
    repeat (3) tick();
    rd(8'h08, v); chk("R6 stopped hold", v, 32'h1234);

    // R8 count write ignored
    wr(8'h08, 32'h0000_0055);
    rd(8'h08, v); chk("R8 count write", v, 32'h1234);
    rd(8'h00, v); chk("R8 ctrl intact", v, 32'h7FFF_FFFE);
    rd(8'h04, v); chk("R8 period intact", v, 32'h1234);

    // R4/R5 periodic sweep
    for (int r = 0; r < 6; r++) begin
      wr(8'h00, 32'h8000_0000);
      wr(8'h04, 32'(r));
      wr(8'h00, 32'h0000_0001);
      exp_cnt = 16'(r);
      for (int k = 0; k < 2 * (r + 1) + 1; k++) begin
        tick();
        exp_cnt = (exp_cnt == 0) ? 16'(r) : exp_cnt - 1'b1;
        rd(8'h08, v);
        chk(exp_cnt == 16'(r) ? "R5 wrap" : "R4 decrement", v, {16'h0, exp_cnt});
      end
    end

    // R4 upper count bits and R6 hold after disable
    wr(8'h04, 32'h0000_FFFF);
    tick(); tick();
    rd(8'h08, v); chk("R4 large decrement", v, 32'h0000_FFFD);
    wr(8'h00, 32'h0000_0000);
    repeat (4) tick();
    rd(8'h08, v); chk("R6 disable hold", v, 32'h0000_FFFD);
    wr(8'h00, 32'h0000_0001);
    tick();
    rd(8'h08, v); chk("R4 resume", v, 32'h0000_FFFC);

    // R11 write vs tick collision
    @(negedge clk); wr_en = 1; tick_en = 1; addr = 8'h04; wdata = 32'h0000_0010;
    @(negedge clk); wr_en = 0; tick_en = 0;
    rd(8'h08, v); chk("R11 write wins", v, 32'h10);

    // R10 hold
    rd(8'h04, held);
    repeat (3) tick();
    chk("R10 rdata hold", rdata, 32'h10);
    rd(8'h08, v); chk("R10 new read", v, 32'h0D);

    // R7 clear
    wr(8'h00, 32'h8000_0001);
    rd(8'h00, v); chk("R7 ctrl clear", v, 0);
    rd(8'h04, v); chk("R7 period clear", v, 0);
    rd(8'h08, v); chk("R7 count clear", v, 0);
    tick();
    rd(8'h08, v); chk("R7 stopped after clear", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule